// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing state machine of a 2 Kbit two-wire (I2C) serial memory. It samples SCL and SDA in the system clock domain, finds START and STOP conditions, and checks the device header against a fixed 4-bit class code and three strap inputs. It answers with ACK or NACK by pulling SDA low through an open-drain enable. On the write path, each accepted data byte goes to a page write buffer port and a commit pulse follows the bus STOP. On the read path, bytes are taken from a memory read port and shifted out MSB first.

An 8-bit address counter keeps its value between transactions. Writes advance it only inside the current 16-byte page. Reads advance it over the whole array and wrap from 255 to 0. A selective read is a write header plus byte address, then a repeated START and a read header. While the external write cycle is busy, the engine does not acknowledge its device header, so a master can poll for completion. A protection verdict input is sampled at each write data byte and can refuse it.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START seen while SCL is high restarts header reception from any state, including part-way through a byte. A STOP seen while SCL is high returns the engine to idle with SDA released.
- R2: The device header is `1010` in bits 7..4, the strap value in bits 3..1, and the direction in bit 0 (1 = read, 0 = write). On a match the engine drives SDA low during the 9th clock. On a mismatch it leaves SDA released and ignores the bus until the next START.
- R3: While `busy_i` is high, a matching device header is not acknowledged.
- R4: In a write, the byte address and every data byte are acknowledged. Each data byte is presented on `wr_addr`/`wr_data` with a one-cycle `wr_en`. `wr_commit` pulses once at the STOP or repeated START that ends a write which loaded at least one byte.
- R5: Successive write data bytes use addresses whose low 4 bits increment and wrap modulo 16, while the upper 4 bits stay fixed.
- R6: If `protect_i` is high when a data byte completes, that byte is not acknowledged, `wr_en` does not pulse, and the rest of the transaction is ignored.
- R7: After a read header is acknowledged, the byte at the address counter is sent MSB first, one bit per SCL clock.
- R8: While the master acknowledges, read bytes continue from successive addresses, and address 255 is followed by address 0. A master NACK ends the transfer.
- R9: The address counter persists between transactions: an immediate read returns the byte after the last one read. A selective read begins at the byte address given in its dummy write.
- R10: Without a preceding START, bus activity gets no acknowledge and causes no write.
- R11: The engine changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level, asynchronous |
| sda_i | input | 1 | Bus data level, asynchronous |
| sda_oe | output | 1 | When high, SDA is pulled low |
| strap_i | input | 3 | Device select straps matched against header bits 3..1 |
| busy_i | input | 1 | Internal write cycle in progress |
| protect_i | input | 1 | Write refused for the byte now completing |
| mem_raddr | output | ADDR_W | Address counter driving the memory read port |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_raddr` changes |
| wr_en | output | 1 | One-cycle strobe loading a byte into the page buffer |
| wr_addr | output | ADDR_W | Page buffer byte address |
| wr_data | output | 8 | Page buffer byte value |
| wr_commit | output | 1 | One-cycle pulse that starts the internal write cycle |

## Verification
The hardest case to reach is the boundary between bytes in a multi-byte transfer: a page write that crosses the 16-byte wrap, a sequential read that crosses 255 to 0, and a repeated START dropped in mid-byte. Directed transactions start just below those boundaries. Randomly sized and placed writes are each read back through a selective read. The bench sets the busy and protect inputs at the header and data-byte ACK points to show that the engine refuses there.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic              protect_i,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RDATA} st_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire start_evt = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;

  st_t              st;
  logic [3:0]       cnt;
  logic [7:0]       sh, tx;
  logic             ack_q, rw_q, wrote;
  logic [ADDR_W-1:0] addr_cnt;

  wire dev_hit = (sh[7:4] == DEV_CODE) && (sh[3:1] == strap_i) && !busy_i;
  wire ack_now = (st == S_DEV) ? dev_hit : (st == S_WDATA) ? !protect_i : 1'b1;
  wire [ADDR_W-1:0] page_next =
    {addr_cnt[ADDR_W-1:PAGE_W], addr_cnt[PAGE_W-1:0] + 1'b1};
  wire is_idle = (st == S_IDLE);

  assign mem_raddr = addr_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      ack_q <= 1'b0; rw_q <= 1'b0; wrote <= 1'b0; addr_cnt <= '0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      wr_commit <= 1'b0;
      if (start_evt || stop_evt) begin
        st <= start_evt ? S_DEV : S_IDLE;
        cnt <= '0;
        sda_oe <= 1'b0;
        wr_commit <= wrote;
        wrote <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
          else if (st == S_RDATA) begin
            ack_q <= ~sda_s;
            addr_cnt <= addr_cnt + 1'b1;
          end
        end
        if (scl_fall) begin
          if (cnt == 4'd8) begin
            if (st == S_RDATA) sda_oe <= 1'b0;
            else begin
              sda_oe <= ack_now;
              ack_q <= ack_now;
              if (st == S_DEV) rw_q <= sh[0];
              if (st == S_ADDR) addr_cnt <= sh[ADDR_W-1:0];
              if (st == S_WDATA && ack_now) begin
                wr_en <= 1'b1;
                wr_addr <= addr_cnt;
                wr_data <= sh;
                addr_cnt <= page_next;
                wrote <= 1'b1;
              end
            end
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            sda_oe <= 1'b0;
            if (!ack_q) st <= S_IDLE;
            else if ((st == S_DEV && rw_q) || st == S_RDATA) begin
              st <= S_RDATA;
              sda_oe <= ~mem_rdata[7];
              tx <= {mem_rdata[6:0], 1'b0};
            end else if (st == S_DEV) st <= S_ADDR;
            else if (st == S_ADDR) st <= S_WDATA;
          end else if (cnt != 4'd0 && st == S_RDATA) begin
            sda_oe <= ~tx[7];
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic is_idle,
  input logic protect_i,
  input logic wr_en,
  input logic wr_commit
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s); // R11
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> !sda_oe); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> !sda_oe); // R10
  AST_WR_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(protect_i)); // R6
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, wr_commit})); // R4
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .is_idle(is_idle),
  .protect_i(protect_i), .wr_en(wr_en), .wr_commit(wr_commit)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] HDR_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] HDR_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0, prot = 1'b0;
  logic sda_oe, wr_en, wr_commit;
  logic [7:0] raddr, rdata, wr_addr, wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  eeprom_i2c_slave u_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .protect_i(prot), .mem_raddr(raddr),
    .mem_rdata(rdata), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit));

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int total = 0, bad = 0, n_wr = 0, n_commit = 0, viol = 0;
  bit done = 0;

  always @(posedge clk) begin
    rdata <= mem[raddr];
    if (wr_en) begin mem[wr_addr] <= wr_data; n_wr++; end
    if (wr_commit) n_commit++;
  end

  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(posedge clk) begin
    #1;
    if (rst_n && sda_oe !== prev_oe && scl && prev_scl) viol++;
    prev_oe = sda_oe;
    prev_scl = scl;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] page_step(input logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q(); scl = 1'b1; q(); scl = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; q(); scl = 1'b1;
    repeat (4) @(negedge clk);
    ack = (sda_bus == 1'b0);
    repeat (4) @(negedge clk);
    scl = 1'b0; q();
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1;
      repeat (4) @(negedge clk);
      b[i] = sda_bus;
      repeat (4) @(negedge clk);
      scl = 1'b0;
    end
    sda_m = ~mack; q(); scl = 1'b1; q(); scl = 1'b0; q(); sda_m = 1'b1;
  endtask

  logic [7:0] wbuf [16];

  task automatic do_write(input string req, input logic [7:0] a, input int n);
    logic ack; int acks = 0; logic [7:0] p = a;
    i2c_start();
    wr_byte(HDR_W, ack); acks += ack;
    wr_byte(a, ack); acks += ack;
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack); acks += ack;
      exp_mem[p] = wbuf[i];
      p = page_step(p);
    end
    i2c_stop();
    check(req, acks, n + 2);
  endtask

  task automatic sel_read(input string req, input logic [7:0] a, input int n);
    logic ack; int acks = 0; logic [7:0] d;
    i2c_start();
    wr_byte(HDR_W, ack); acks += ack;
    wr_byte(a, ack); acks += ack;
    i2c_start();
    wr_byte(HDR_R, ack); acks += ack;
    check(req, acks, 3);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, d);
      check(req, d, exp_mem[8'(a + i)]);
    end
    i2c_stop();
  endtask

  task automatic imm_read(input string req, input logic [7:0] expd);
    logic ack; logic [7:0] d;
    i2c_start();
    wr_byte(HDR_R, ack);
    check(req, ack, 1);
    rd_byte(1'b0, d);
    i2c_stop();
    check(req, d, expd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack; logic [7:0] d; int w0, c0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; exp_mem[i] = 8'(i) ^ 8'h5A; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 reset oe", sda_oe, 0);
    check("R10 reset wr_en", wr_en, 0);

    wr_byte(HDR_W, ack);
    check("R10 no start ack", ack, 0);
    i2c_stop();

    i2c_start();
    wr_byte({4'b1010, 3'b000, 1'b0}, ack);
    check("R2 strap mismatch nack", ack, 0);
    wr_byte(HDR_W, ack);
    check("R2 ignored until start", ack, 0);
    i2c_stop();
    check("R10 no writes", n_wr, 0);

    wbuf[0] = 8'hA5;
    do_write("R2 R4 byte write acks", 8'h10, 1);
    repeat (4) @(negedge clk);
    check("R4 stored", mem[8'h10], 8'hA5);
    check("R4 commit", n_commit, 1);

    busy = 1'b1;
    i2c_start(); wr_byte(HDR_W, ack); i2c_stop();
    check("R3 busy nack", ack, 0);
    busy = 1'b0;
    i2c_start(); wr_byte(HDR_W, ack); i2c_stop();
    check("R3 ready ack", ack, 1);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write("R5 page acks", 8'h3E, 4);
    repeat (4) @(negedge clk);
    check("R5 3E", mem[8'h3E], 8'h11);
    check("R5 3F", mem[8'h3F], 8'h22);
    check("R5 wrap 30", mem[8'h30], 8'h33);
    check("R5 wrap 31", mem[8'h31], 8'h44);
    check("R5 40 untouched", mem[8'h40], 8'h40 ^ 8'h5A);

    w0 = n_wr; c0 = n_commit;
    prot = 1'b1;
    i2c_start(); wr_byte(HDR_W, ack); wr_byte(8'h20, ack);
    wr_byte(8'h77, ack);
    check("R6 protected nack", ack, 0);
    prot = 1'b0;
    wr_byte(8'h88, ack);
    check("R6 rest ignored", ack, 0);
    i2c_stop();
    repeat (4) @(negedge clk);
    check("R6 mem kept", mem[8'h20], 8'h20 ^ 8'h5A);
    check("R6 no wr", n_wr, w0);
    check("R6 no commit", n_commit, c0);

    sel_read("R7 R9 selective", 8'h10, 1);
    imm_read("R9 counter persists", exp_mem[8'h11]);

    sel_read("R8 sequential wrap", 8'hFE, 3);
    imm_read("R8 R9 after wrap", exp_mem[8'h01]);

    i2c_start(); wr_byte(HDR_W, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_start(); wr_byte(HDR_R, ack);
    check("R1 restart mid byte ack", ack, 1);
    rd_byte(1'b0, d);
    i2c_stop();
    check("R1 restart read data", d, exp_mem[8'h02]);

    for (int it = 0; it < 14; it++) begin
      logic [7:0] a; int n;
      a = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      c0 = n_commit;
      do_write("R4 R5 random write", a, n);
      repeat (4) @(negedge clk);
      check("R4 random commit", n_commit, c0 + 1);
      sel_read("R8 random readback", a, n);
    end

    check("R11 sda drive edges", viol, 0);
    finish_run();
  end
endmodule